// File: doc/BRIEF.md
# Transmit Descriptor Queue Engine

This block is the transmit-side control engine for one network port. Host software places transmit descriptors in a circular send ring in host memory. It then announces new work by writing the new producer index to a doorbell register in the engine. The engine compares its own consumer index with that producer index. For each pending slot it reads the descriptor through a simple memory read port, advances its consumer index, and asks a DMA engine to move the packet bytes toward the MAC. When the DMA reports the end of the transfer, the engine writes a completion entry into a circular completion ring and raises a level interrupt.

Only one descriptor is in flight at any time. The engine fetches the next descriptor only after the memory system has accepted the completion write for the previous one. The interrupt stays high until software writes a clear bit in the control register. A completion that lands in the same cycle as a clear keeps the interrupt set.

Top module: `nic_tx_queue_engine`

## Requirements
- R1: After reset, rd_req, dma_req, cq_wr_req and irq are low, and no fetch is issued until a doorbell write makes the ring non-empty.
- R2: The send ring is empty when the consumer index equals the producer index. A doorbell write whose value equals the current consumer index starts no fetch.
- R3: The fetch address is SQ_BASE + 8 * consumer index. The consumer index advances by one per accepted fetch and wraps modulo RING_DEPTH (16 by default).
- R4: The 64-bit descriptor has the buffer address in bits [47:0], the destination port in bits [55:48] and the byte length in bits [63:56]. dma_req rises in the cycle after rd_valid, carries those three fields, and stays high and stable until dma_done.
- R5: At most one of rd_req, dma_req and cq_wr_req is high at a time. The next fetch starts only after cq_wr_ack.
- R6: cq_wr_req rises in the cycle after dma_done. Its address is CQ_BASE + 2 * completion index. Its data is {status, slot}, with the slot index in bits [IDX_W-1:0] and status in bit IDX_W. Status is 1 when dma_err was low at dma_done. The completion index advances by one per cq_wr_ack and wraps modulo RING_DEPTH.
- R7: irq goes high in the cycle after cq_wr_ack and stays high until a register write with reg_sel = 1 (control) and reg_wdata bit 0 = 1. A control write with bit 0 = 0 leaves it unchanged, and so does a doorbell write (reg_sel = 0).
- R8: When cq_wr_ack and a clearing control write occur in the same cycle, irq is high afterwards.
- R9: rd_req with rd_addr stays asserted and stable until rd_valid. cq_wr_req with its address and data stays asserted and stable until cq_wr_ack.
- R10: Doorbell writes made while a descriptor is in flight extend the pending work. Every slot up to the new producer index is served in ring order, and the engine goes idle once the ring is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 doorbell, 1 control |
| reg_wdata | input | IDX_W | Doorbell: new producer index; control: bit 0 clears irq |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | 48 | Descriptor byte address |
| rd_valid | input | 1 | Descriptor read data valid (ends the request) |
| rd_data | input | 64 | Descriptor read data |
| dma_req | output | 1 | DMA transfer request |
| dma_addr | output | 48 | Packet buffer address |
| dma_port | output | 8 | Destination port |
| dma_len | output | 8 | Packet length in bytes |
| dma_done | input | 1 | DMA transfer finished |
| dma_err | input | 1 | DMA transfer error, valid with dma_done |
| cq_wr_req | output | 1 | Completion write request |
| cq_wr_addr | output | 48 | Completion entry byte address |
| cq_wr_data | output | IDX_W+1 | Completion entry {status, slot} |
| cq_wr_ack | input | 1 | Completion write accepted |
| irq | output | 1 | Level interrupt |

## Verification
A doorbell write takes effect at the clock edge that samples it, and rd_req appears one edge later. dma_req follows one edge after the rd_valid edge, cq_wr_req follows one edge after the dma_done edge, and irq follows one edge after the cq_wr_ack edge. The bench drives every response on a falling edge. It checks each result on the falling edge that follows the rising edge where that result is due. While it withholds a response for a varied number of cycles, it rechecks on every falling edge that the pending request is still held. It sweeps every batch size from 0 to 15, so the indices wrap several times. Descriptor contents, error flags and response latencies are computed arithmetically from the slot and the batch number.

// File: rtl/nic_txq_pkg.sv
// Package: shared constants and types of the transmit descriptor queue engine.
// Assumes a 48-bit host address space and 64-bit descriptors.
package nic_txq_pkg;
    localparam int HOST_AW = 48;
    localparam int DESC_W  = 64;
    localparam int DESC_BYTES_LOG2 = 3;

    // Register select encodings
    localparam logic REG_DOORBELL = 1'b0;
    localparam logic REG_CTRL     = 1'b1;

    // Descriptor as held in host memory: length on top, address at bottom
    typedef struct packed {
        logic [7:0]         len;
        logic [7:0]         port;
        logic [HOST_AW-1:0] addr;
    } txq_desc_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DMA   = 2'd2,
        ST_CPL   = 2'd3
    } txq_state_e;
endpackage

// File: rtl/txq_ring_ptr.sv
// Module: ring index counter. Advances by one on each strobe and wraps
// naturally at 2**IDX_W. Assumes the ring depth is a power of two.
module txq_ring_ptr #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);
    // Purpose: hold the index and step it on each advance strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv)
            ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/txq_ctrl_regs.sv
// Module: software-visible write registers. Holds the producer index
// written through the doorbell and the sticky interrupt level.
// Assumes one register write per cycle. A completion beats a clear.
module txq_ctrl_regs import nic_txq_pkg::*; #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic             reg_sel,
    input  logic [IDX_W-1:0] reg_wdata,
    input  logic             cpl_done,
    output logic [IDX_W-1:0] sq_tail,
    output logic             irq
);
    logic db_wr;
    logic clr_wr;

    assign db_wr  = reg_wr_en && (reg_sel == REG_DOORBELL);
    assign clr_wr = reg_wr_en && (reg_sel == REG_CTRL) && reg_wdata[0];

    // Purpose: capture the producer index from a doorbell write
    always_ff @(posedge clk) begin
        if (!rst_n)
            sq_tail <= '0;
        else if (db_wr)
            sq_tail <= reg_wdata;
    end

    // Purpose: set irq on completion, clear on control write, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (cpl_done)
            irq <= 1'b1;
        else if (clr_wr)
            irq <= 1'b0;
    end
endmodule

// File: rtl/txq_sequencer.sv
// Module: per-descriptor sequencer. Steps through fetch, DMA and
// completion write for one descriptor at a time, holding each request
// until its handshake arrives. Assumes the responders answer eventually.
module txq_sequencer import nic_txq_pkg::*; #(
    parameter int                 IDX_W          = 4,
    parameter logic [HOST_AW-1:0] SQ_BASE        = 48'h0000_0001_0000,
    parameter logic [HOST_AW-1:0] CQ_BASE        = 48'h0000_0002_0000,
    parameter int                 CQE_BYTES_LOG2 = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   sq_head,
    input  logic [IDX_W-1:0]   sq_tail,
    input  logic [IDX_W-1:0]   cq_tail,
    output logic               head_adv,
    output logic               cq_adv,
    output logic               rd_req,
    output logic [HOST_AW-1:0] rd_addr,
    input  logic               rd_valid,
    input  logic [DESC_W-1:0]  rd_data,
    output logic               dma_req,
    output logic [HOST_AW-1:0] dma_addr,
    output logic [7:0]         dma_port,
    output logic [7:0]         dma_len,
    input  logic               dma_done,
    input  logic               dma_err,
    output logic               cq_wr_req,
    output logic [HOST_AW-1:0] cq_wr_addr,
    output logic [IDX_W:0]     cq_wr_data,
    input  logic               cq_wr_ack
);
    localparam int PAD_W = HOST_AW - IDX_W;

    txq_state_e state_q, state_d;
    txq_desc_t  desc_q;
    logic [IDX_W-1:0] slot_q;
    logic             ok_q;

    // Purpose: next-state decision from ring occupancy and handshakes
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sq_head != sq_tail) state_d = ST_FETCH;
            ST_FETCH: if (rd_valid)           state_d = ST_DMA;
            ST_DMA:   if (dma_done)           state_d = ST_CPL;
            ST_CPL:   if (cq_wr_ack)          state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // Purpose: state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign head_adv = (state_q == ST_FETCH) && rd_valid;
    assign cq_adv   = (state_q == ST_CPL) && cq_wr_ack;

    // Purpose: latch the fetched descriptor, its slot and the DMA outcome
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q <= '0;
            slot_q <= '0;
            ok_q   <= 1'b0;
        end else begin
            if (head_adv) begin
                desc_q <= txq_desc_t'(rd_data);
                slot_q <= sq_head;
            end
            if ((state_q == ST_DMA) && dma_done)
                ok_q <= !dma_err;
        end
    end

    // Request outputs decoded from the state
    assign rd_req     = (state_q == ST_FETCH);
    assign rd_addr    = SQ_BASE + ({{PAD_W{1'b0}}, sq_head} << DESC_BYTES_LOG2);
    assign dma_req    = (state_q == ST_DMA);
    assign dma_addr   = desc_q.addr;
    assign dma_port   = desc_q.port;
    assign dma_len    = desc_q.len;
    assign cq_wr_req  = (state_q == ST_CPL);
    assign cq_wr_addr = CQ_BASE + ({{PAD_W{1'b0}}, cq_tail} << CQE_BYTES_LOG2);
    assign cq_wr_data = {ok_q, slot_q};
endmodule

// File: rtl/nic_tx_queue_engine.sv
// Module: top of the transmit descriptor queue engine for one port.
// Connects the register block, the consumer and completion index counters
// and the sequencer. Assumes RING_DEPTH is a power of two and both rings
// share that depth.
module nic_tx_queue_engine import nic_txq_pkg::*; #(
    parameter int                 RING_DEPTH     = 16,
    parameter logic [HOST_AW-1:0] SQ_BASE        = 48'h0000_0001_0000,
    parameter logic [HOST_AW-1:0] CQ_BASE        = 48'h0000_0002_0000,
    parameter int                 CQE_BYTES_LOG2 = 1,
    localparam int                IDX_W          = $clog2(RING_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic               reg_sel,
    input  logic [IDX_W-1:0]   reg_wdata,
    output logic               rd_req,
    output logic [HOST_AW-1:0] rd_addr,
    input  logic               rd_valid,
    input  logic [DESC_W-1:0]  rd_data,
    output logic               dma_req,
    output logic [HOST_AW-1:0] dma_addr,
    output logic [7:0]         dma_port,
    output logic [7:0]         dma_len,
    input  logic               dma_done,
    input  logic               dma_err,
    output logic               cq_wr_req,
    output logic [HOST_AW-1:0] cq_wr_addr,
    output logic [IDX_W:0]     cq_wr_data,
    input  logic               cq_wr_ack,
    output logic               irq
);
    logic [IDX_W-1:0] sq_head;
    logic [IDX_W-1:0] sq_tail;
    logic [IDX_W-1:0] cq_tail;
    logic             head_adv;
    logic             cq_adv;

    txq_ctrl_regs #(.IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .cpl_done  (cq_adv),
        .sq_tail   (sq_tail),
        .irq       (irq)
    );

    txq_ring_ptr #(.IDX_W(IDX_W)) u_sq_head (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (head_adv),
        .ptr   (sq_head)
    );

    txq_ring_ptr #(.IDX_W(IDX_W)) u_cq_tail (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (cq_adv),
        .ptr   (cq_tail)
    );

    txq_sequencer #(
        .IDX_W          (IDX_W),
        .SQ_BASE        (SQ_BASE),
        .CQ_BASE        (CQ_BASE),
        .CQE_BYTES_LOG2 (CQE_BYTES_LOG2)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sq_head    (sq_head),
        .sq_tail    (sq_tail),
        .cq_tail    (cq_tail),
        .head_adv   (head_adv),
        .cq_adv     (cq_adv),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .dma_req    (dma_req),
        .dma_addr   (dma_addr),
        .dma_port   (dma_port),
        .dma_len    (dma_len),
        .dma_done   (dma_done),
        .dma_err    (dma_err),
        .cq_wr_req  (cq_wr_req),
        .cq_wr_addr (cq_wr_addr),
        .cq_wr_data (cq_wr_data),
        .cq_wr_ack  (cq_wr_ack)
    );
endmodule

// File: rtl/txq_engine_checker.sv
// Module: protocol checker bound to the engine top. Watches only ports.
module txq_engine_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_req,
    input logic        rd_valid,
    input logic [47:0] rd_addr,
    input logic        dma_req,
    input logic        dma_done,
    input logic [47:0] dma_addr,
    input logic [7:0]  dma_port,
    input logic [7:0]  dma_len,
    input logic        cq_wr_req,
    input logic        cq_wr_ack,
    input logic [47:0] cq_wr_addr,
    input logic        irq,
    input logic        ctrl_clr
);
    // R5: a single phase is active at a time
    assert_single_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req, dma_req, cq_wr_req}));

    // R9: fetch request held with a stable address until data returns
    assert_fetch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_valid |=> rd_req && $stable(rd_addr));

    // R4: DMA starts right after the fetch and holds its fields until done
    assert_dma_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_valid |=> dma_req);
    assert_dma_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && !dma_done |=> dma_req && $stable(dma_addr)
                                 && $stable(dma_port) && $stable(dma_len));

    // R6: completion write follows the end of the DMA
    assert_cpl_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && dma_done |=> cq_wr_req);

    // R9: completion write held until accepted
    assert_cpl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cq_wr_req && !cq_wr_ack |=> cq_wr_req && $stable(cq_wr_addr));

    // R5: no fetch in the cycle after an accepted completion
    assert_no_early_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cq_wr_req && cq_wr_ack |=> !rd_req);

    // R7/R8: irq rises after an accepted completion, even with a clear
    assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cq_wr_req && cq_wr_ack |=> irq);

    // R7: irq is sticky without a clear
    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !ctrl_clr |=> irq);

    // R7: irq does not rise without a completion
    assert_irq_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq && !(cq_wr_req && cq_wr_ack) |=> !irq);
endmodule

bind nic_tx_queue_engine txq_engine_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .rd_valid   (rd_valid),
    .rd_addr    (rd_addr),
    .dma_req    (dma_req),
    .dma_done   (dma_done),
    .dma_addr   (dma_addr),
    .dma_port   (dma_port),
    .dma_len    (dma_len),
    .cq_wr_req  (cq_wr_req),
    .cq_wr_ack  (cq_wr_ack),
    .cq_wr_addr (cq_wr_addr),
    .irq        (irq),
    .ctrl_clr   (reg_wr_en && (reg_sel == nic_txq_pkg::REG_CTRL) && reg_wdata[0])
);

// File: tb/test_nic_tx_queue_engine.sv
// Bench: sweeps batch sizes 0..15 over the 16-entry rings, models the
// descriptor memory, DMA and completion responders, checks at falling edges.
module test_nic_tx_queue_engine;
    localparam logic [47:0] SQB = 48'h0000_0001_0000;
    localparam logic [47:0] CQB = 48'h0000_0002_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [3:0]  reg_wdata = '0;
    logic        rd_req;
    logic [47:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [63:0] rd_data = '0;
    logic        dma_req;
    logic [47:0] dma_addr;
    logic [7:0]  dma_port;
    logic [7:0]  dma_len;
    logic        dma_done = 1'b0;
    logic        dma_err = 1'b0;
    logic        cq_wr_req;
    logic [47:0] cq_wr_addr;
    logic [4:0]  cq_wr_data;
    logic        cq_wr_ack = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [3:0] exp_head = '0;
    logic [3:0] exp_cq = '0;

    always #4 clk = ~clk;

    nic_tx_queue_engine #(
        .RING_DEPTH (16),
        .SQ_BASE    (SQB),
        .CQ_BASE    (CQB)
    ) i_nic_tx_queue_engine (
        .clk (clk), .rst_n (rst_n),
        .reg_wr_en (reg_wr_en), .reg_sel (reg_sel), .reg_wdata (reg_wdata),
        .rd_req (rd_req), .rd_addr (rd_addr), .rd_valid (rd_valid), .rd_data (rd_data),
        .dma_req (dma_req), .dma_addr (dma_addr), .dma_port (dma_port), .dma_len (dma_len),
        .dma_done (dma_done), .dma_err (dma_err),
        .cq_wr_req (cq_wr_req), .cq_wr_addr (cq_wr_addr), .cq_wr_data (cq_wr_data),
        .cq_wr_ack (cq_wr_ack), .irq (irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] desc_of(input int slot, input int p);
        logic [7:0]  len;
        logic [7:0]  port;
        logic [47:0] addr;
        len  = 8'((slot * 13 + p * 5 + 1) & 255);
        port = 8'((slot * 7 + p) & 255);
        addr = 48'h0000_4000_0000 + 48'(p) * 48'h1_0000 + 48'(slot) * 48'h100 + 48'(p & 7);
        return {len, port, addr};
    endfunction

    // Starts and ends just after a falling edge
    task automatic reg_write(input logic sel, input logic [3:0] data);
        reg_wr_en = 1'b1;
        reg_sel   = sel;
        reg_wdata = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_wdata = '0;
    endtask

    // Serves one descriptor through fetch, DMA and completion
    task automatic serve_one(input int p, input bit extra_db, input logic [3:0] extra_tail,
                             input bit clr_at_ack);
        int slot, rl, dl, al, guard;
        logic [63:0] d;
        logic err;
        slot = int'(exp_head);
        rl = (slot + p) % 3;
        dl = (slot * p) % 4 + (extra_db ? 1 : 0);
        al = p % 2;
        err = ((slot + p) % 5) == 3;
        d = desc_of(slot, p);
        guard = 0;
        while (!rd_req && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk("R3 fetch request seen", 64'(rd_req), 64'd1);
        chk("R3 fetch address", 64'(rd_addr), 64'(SQB + 48'(exp_head) * 48'd8));
        chk("R5 no dma/cpl during fetch", 64'({dma_req, cq_wr_req}), 64'd0);
        for (int i = 0; i < rl; i++) begin
            @(negedge clk);
            chk("R9 fetch held", 64'({rd_req, rd_addr}), 64'({1'b1, SQB + 48'(exp_head) * 48'd8}));
        end
        rd_valid = 1'b1;
        rd_data  = d;
        @(negedge clk);
        rd_valid = 1'b0;
        rd_data  = '0;
        exp_head = exp_head + 1'b1;
        chk("R4 dma_req after fetch", 64'({dma_req, rd_req}), 64'b10);
        chk("R4 dma address", 64'(dma_addr), 64'(d[47:0]));
        chk("R4 dma port", 64'(dma_port), 64'(d[55:48]));
        chk("R4 dma length", 64'(dma_len), 64'(d[63:56]));
        for (int i = 0; i < dl; i++) begin
            if (extra_db && i == 0) reg_write(1'b0, extra_tail);
            else @(negedge clk);
            chk("R4 dma held", 64'({dma_req, dma_len, dma_port, dma_addr}),
                64'({1'b1, d}));
        end
        dma_done = 1'b1;
        dma_err  = err;
        @(negedge clk);
        dma_done = 1'b0;
        dma_err  = 1'b0;
        chk("R6 cq_wr_req after dma", 64'({cq_wr_req, dma_req}), 64'b10);
        chk("R6 completion address", 64'(cq_wr_addr), 64'(CQB + 48'(exp_cq) * 48'd2));
        chk("R6 completion data", 64'(cq_wr_data), 64'({~err, 4'(slot)}));
        for (int i = 0; i < al; i++) begin
            @(negedge clk);
            chk("R9 completion held", 64'({cq_wr_req, cq_wr_data}), 64'({1'b1, ~err, 4'(slot)}));
        end
        cq_wr_ack = 1'b1;
        if (clr_at_ack) begin
            reg_wr_en = 1'b1;
            reg_sel   = 1'b1;
            reg_wdata = 4'd1;
        end
        @(negedge clk);
        cq_wr_ack = 1'b0;
        reg_wr_en = 1'b0;
        reg_wdata = '0;
        exp_cq = exp_cq + 1'b1;
        if (clr_at_ack) chk("R8 set wins over clear", 64'(irq), 64'd1);
        else            chk("R7 irq after completion", 64'(irq), 64'd1);
        chk("R5 no fetch right after ack", 64'({rd_req, cq_wr_req}), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic prev_irq;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset outputs", 64'({rd_req, dma_req, cq_wr_req, irq}), 64'd0);
        repeat (10) @(negedge clk);
        chk("R1 no fetch without doorbell", 64'(rd_req), 64'd0);

        for (int p = 0; p < 16; p++) begin
            prev_irq = irq;
            reg_write(1'b0, exp_head + 4'(p));
            chk("R7 doorbell leaves irq", 64'(irq), 64'(prev_irq));
            reg_write(1'b1, 4'd0);
            chk("R7 control bit0=0 leaves irq", 64'(irq), 64'(prev_irq));
            reg_write(1'b1, 4'd1);
            chk("R7 control clear", 64'(irq), 64'd0);
            if (p == 0) begin
                for (int i = 0; i < 12; i++) begin
                    @(negedge clk);
                    chk("R2 empty ring starts no fetch", 64'(rd_req), 64'd0);
                end
            end
            for (int j = 0; j < p; j++)
                serve_one(p, 1'b0, 4'd0, j == 1);
            repeat (6) @(negedge clk);
            chk("R10 idle once ring empty", 64'({rd_req, dma_req, cq_wr_req}), 64'd0);
        end

        // R2 at a non-zero index: doorbell equal to current index
        reg_write(1'b0, exp_head);
        repeat (8) @(negedge clk);
        chk("R2 doorbell equal to head", 64'(rd_req), 64'd0);

        // R10: extend the ring while a descriptor is in flight
        reg_write(1'b0, exp_head + 4'd2);
        serve_one(20, 1'b1, exp_head + 4'd5, 1'b0);
        for (int j = 0; j < 4; j++)
            serve_one(20, 1'b0, 4'd0, 1'b0);
        repeat (6) @(negedge clk);
        chk("R10 all extended slots served", 64'({rd_req, exp_head}), 64'({1'b0, 4'd13}));

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule